// File: doc/BRIEF.md
# Symmetric Folded Distributed-Arithmetic FIR Filter

This block is a linear-phase FIR filter that uses no multipliers. Parallel two's-complement samples arrive with a valid strobe. Each accepted sample moves a tap delay line forward, and a copy of every tap is loaded into a serial shift register.

Over one word time the block works one bit per clock, least significant bit first. Each pair of taps that shares a coefficient is summed by its own serial adder with a carry flop. The pair sums form an address into a partial-sum table. The table is built at elaboration from the half-length coefficient parameter. An accumulator adds each table value at a fixed high position and then halves the total. On the final clock, which carries the sign of the pair sums, the table value is subtracted instead of added. The full-precision result then leaves the block with a one-cycle valid pulse.

A word time lasts `DATA_W+1` clocks. The extra clock holds the carry of the pair sums. A new sample can be taken in the last clock of a word, so the block accepts one sample every `DATA_W+1` cycles.

Top module: `sym_da_fir`

## Requirements
- R1: While reset is held and just after it is released, `outValid` is 0 and `outData` is 0.
- R2: Each result equals the sum over i = 0 to TAPS-1 of h[i]·x[n-i], computed exactly in two's complement at full width. x[n] is the newest accepted sample. h[i] = h[TAPS-1-i] = c[min(i, TAPS-1-i)], and c[k] is the signed field `COEFS[k*COEF_W +: COEF_W]`.
- R3: If a sample is accepted on clock edge E, `outValid` is high in exactly the cycle that begins at edge E+DATA_W+1. It is low in the cycles before that.
- R4: A sample is accepted whenever `inValid` is high and the block is either idle or in the last bit clock of a word, which is the cycle ending at edge E+DATA_W+1. Samples sent back to back in that cycle produce one result every DATA_W+1 cycles, none lost.
- R5: `inValid` pulses during any other cycle of a word are ignored. They do not change the tap line, they do not change later results, and they produce no extra `outValid` pulse.
- R6: `outData` keeps its value in every cycle in which `outValid` is low.
- R7: Results stay exact at the extremes. This includes the most negative input on every tap, the most positive input on every tap, and alternating extremes.
- R8: After reset the tap history is all zero, so the first results depend only on the samples accepted since reset.
- R9: `outValid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | OUT_W | Signed full-precision result |

## Verification
Two events can fall in the same cycle: the sign-bit subtraction that completes one result, and the loading of the next sample, which clears the accumulator and reloads the serial registers. The bench provokes this by streaming samples back to back. Each new sample is driven exactly in the last bit clock of the running word. The test sweeps all pairs of consecutive values of a 4-bit input. Every result is compared against a direct integer convolution. A result lost or corrupted by the overlap would show up as a mismatch or as a missing pulse.

// File: rtl/sym_da_pkg.sv
package sym_da_pkg;

  // strobes from sequencing control to the arithmetic datapath
  typedef struct packed {
    logic load;     // take a new sample, restart the word
    logic step;     // process one serial bit this cycle
    logic signBit;  // this bit carries the sign of the pair sums
  } daStrobe_t;

endpackage

// File: rtl/sym_da_ctrl.sv
module sym_da_ctrl
  import sym_da_pkg::*;
#(
  parameter int WORD_BITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output daStrobe_t strb
);

  localparam int CNT_W = $clog2(WORD_BITS);

  logic             busy;
  logic [CNT_W-1:0] bitIdx;
  logic             lastBit;
  logic             accept;

  assign lastBit = busy && (bitIdx == CNT_W'(WORD_BITS - 1));
  // new samples enter only between words
  assign accept  = inValid && (!busy || lastBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (lastBit) begin
      busy   <= 1'b0;
    end else if (busy) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.step    = busy;
    strb.signBit = lastBit;
  end

endmodule

// File: rtl/sym_da_lut.sv
module sym_da_lut #(
  parameter int                      PAIRS  = 4,
  parameter int                      COEF_W = 10,
  parameter logic [PAIRS*COEF_W-1:0] COEFS  = '0,
  parameter int                      LUT_W  = COEF_W + 3
) (
  input  logic        [PAIRS-1:0] addr,
  output logic signed [LUT_W-1:0] value
);

  localparam int DEPTH = 2 ** PAIRS;

  function automatic logic signed [LUT_W-1:0] subsetSum(int unsigned sel);
    int total;
    logic signed [COEF_W-1:0] c;
    total = 0;
    for (int k = 0; k < PAIRS; k++) begin
      c = COEFS[k*COEF_W +: COEF_W];
      if (sel[k]) total += int'(c);
    end
    return LUT_W'(total);
  endfunction

  logic signed [LUT_W-1:0] partSums [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign partSums[e] = subsetSum(e);
  end

  assign value = partSums[addr];

endmodule

// File: rtl/sym_da_datapath.sv
module sym_da_datapath
  import sym_da_pkg::*;
#(
  parameter int                         TAPS   = 8,
  parameter int                         DATA_W = 8,
  parameter int                         COEF_W = 10,
  parameter logic [TAPS/2*COEF_W-1:0]   COEFS  = '0,
  parameter int                         ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  daStrobe_t                strb,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  localparam int PAIRS     = TAPS / 2;
  localparam int WORD_BITS = DATA_W + 1;
  localparam int LUT_W     = COEF_W + $clog2(PAIRS) + 1;

  logic signed [DATA_W-1:0] taps   [TAPS];
  logic        [DATA_W-1:0] serial [TAPS];
  logic        [PAIRS-1:0]  carry, carryNext, sumBit;
  logic signed [LUT_W-1:0]  lutValue;
  logic signed [ACC_W-1:0]  acc, lutWide, partial, accNext;

  // tap line and serial copies; serial registers sign-extend as they shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) begin
        taps[i]   <= '0;
        serial[i] <= '0;
      end
    end else if (strb.load) begin
      taps[0]   <= inData;
      serial[0] <= inData;
      for (int i = 1; i < TAPS; i++) begin
        taps[i]   <= taps[i-1];
        serial[i] <= taps[i-1];
      end
    end else if (strb.step) begin
      for (int i = 0; i < TAPS; i++)
        serial[i] <= {serial[i][DATA_W-1], serial[i][DATA_W-1:1]};
    end
  end

  // one serial adder per symmetric pair
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic bitA, bitB;
    assign bitA         = serial[k][0];
    assign bitB         = serial[TAPS-1-k][0];
    assign sumBit[k]    = bitA ^ bitB ^ carry[k];
    assign carryNext[k] = (bitA & bitB) | (bitA & carry[k]) | (bitB & carry[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          carry <= '0;
    else if (strb.load) carry <= '0;
    else if (strb.step) carry <= carryNext;
  end

  sym_da_lut #(
    .PAIRS (PAIRS),
    .COEF_W(COEF_W),
    .COEFS (COEFS),
    .LUT_W (LUT_W)
  ) u_lut (
    .addr (sumBit),
    .value(lutValue)
  );

  // add at the top, halve every bit; subtract on the sign bit
  always_comb begin
    lutWide = ACC_W'(lutValue);
    partial = strb.signBit ? -lutWide : lutWide;
    accNext = (acc + (partial <<< WORD_BITS)) >>> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          acc <= '0;
    else if (strb.load) acc <= '0;
    else if (strb.step) acc <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.step && strb.signBit;
      if (strb.step && strb.signBit) outData <= accNext;
    end
  end

endmodule

// File: rtl/sym_da_fir.sv
module sym_da_fir
  import sym_da_pkg::*;
#(
  parameter int                       TAPS   = 8,
  parameter int                       DATA_W = 8,
  parameter int                       COEF_W = 10,
  parameter logic [TAPS/2*COEF_W-1:0] COEFS  = {10'd300, 10'h3A6, 10'd40, 10'h3F9},
  localparam int OUT_W = COEF_W + $clog2(TAPS/2) + 1 + DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);

  daStrobe_t strb;

  sym_da_ctrl #(
    .WORD_BITS(DATA_W + 1)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .strb   (strb)
  );

  sym_da_datapath #(
    .TAPS  (TAPS),
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .COEFS (COEFS),
    .ACC_W (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: rtl/sym_da_fir_chk.sv
module sym_da_fir_chk #(
  parameter int WORD_BITS = 9,
  parameter int OUT_W     = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             load,
  input logic             outValid,
  input logic [OUT_W-1:0] outData
);

  localparam int CW = $clog2(WORD_BITS + 1);

  // cycles since the last accepted sample, saturating at one word
  logic [CW-1:0] sinceLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                              sinceLoad <= '0;
    else if (load)                                          sinceLoad <= CW'(1);
    else if (sinceLoad != '0 && sinceLoad < CW'(WORD_BITS)) sinceLoad <= sinceLoad + 1'b1;
  end

  AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (sinceLoad == '0 || sinceLoad == CW'(WORD_BITS)) |-> load); // R4
  AST_IGNORE_MIDWORD: assert property (@(posedge clk) disable iff (!rstN)
    load |-> (sinceLoad == '0 || sinceLoad == CW'(WORD_BITS))); // R5
  AST_LOAD_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    load |-> inValid); // R5
  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceLoad == CW'(WORD_BITS) && $past(sinceLoad) == CW'(WORD_BITS - 1)) |=> outValid); // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R9
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData)); // R6

endmodule

bind sym_da_fir sym_da_fir_chk #(
  .WORD_BITS(DATA_W + 1),
  .OUT_W    (OUT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .load    (strb.load),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/sym_da_fir_tb.sv
`timescale 1ns/1ps
module sym_da_fir_tb;

  localparam int TAPS   = 6;
  localparam int DATA_W = 4;
  localparam int COEF_W = 6;
  localparam int P      = DATA_W + 1;
  localparam int OUT_W  = COEF_W + $clog2(TAPS/2) + 1 + DATA_W + 2;
  // c0 = 5, c1 = -13, c2 = 27
  localparam logic [TAPS/2*COEF_W-1:0] COEFS = {6'd27, 6'b110011, 6'd5};

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     inValid = 1'b0;
  logic signed [DATA_W-1:0] inData = '0;
  logic                     outValid;
  logic signed [OUT_W-1:0]  outData;

  sym_da_fir #(
    .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .COEFS(COEFS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always #2.5 clk = ~clk;

  int    hb [TAPS] = '{5, -13, 27, 27, -13, 5};
  int    model [TAPS];
  int    expQ [$];
  int    nRun = 0, nFail = 0, pulses = 0, accepted = 0;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushSample(int v);
    int y = 0;
    for (int i = TAPS - 1; i > 0; i--) model[i] = model[i-1];
    model[0] = v;
    for (int i = 0; i < TAPS; i++) y += hb[i] * model[i];
    expQ.push_back(y);
    accepted++;
  endtask

  // compare every result in order against the integer convolution (R2)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      int e;
      pulses++;
      if (expQ.size() == 0) check(1'b0, tag, int'(outData), 0);
      else begin
        e = expQ.pop_front();
        check(int'(outData) == e, tag, int'(outData), e);
      end
    end
  end

  // gap = extra idle cycles; noise = inValid pulses mid-word
  task automatic sendWord(int v, int gap, bit noise);
    @(negedge clk); inValid = 1'b1; inData = DATA_W'(v);
    @(posedge clk); pushSample(v);
    if (noise) begin
      for (int c = 0; c <= P - 2; c++) begin
        @(negedge clk); inValid = 1'b1; inData = DATA_W'(~v + c);
        @(posedge clk);
      end
      @(negedge clk); inValid = 1'b0;
    end else begin
      @(negedge clk); inValid = 1'b0;
      repeat (P - 1) @(posedge clk);
    end
    repeat (gap) @(posedge clk);
  endtask

  task automatic latencyProbe(int v);
    logic signed [OUT_W-1:0] held;
    @(negedge clk); inValid = 1'b1; inData = DATA_W'(v);
    @(posedge clk); pushSample(v);
    @(negedge clk); inValid = 1'b0;
    for (int c = 1; c <= P; c++) begin
      @(negedge clk);
      check(outValid == (c == P), "R3", int'(outValid), int'(c == P));
    end
    held = outData;
    @(negedge clk);
    check(!outValid, "R9", int'(outValid), 0);
    check(outData == held, "R6", int'(outData), int'(held));
    repeat (2) @(negedge clk);
    check(outData == held, "R6", int'(outData), int'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2 watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TAPS; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outData == '0, "R1", int'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", int'(outValid), 0);

    tag = "R8"; latencyProbe(5);
    tag = "R8"; sendWord(-3, 1, 1'b0);
    tag = "R3"; latencyProbe(-7);

    tag = "R2";
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++) begin
        sendWord(a, (a ^ b) & 1, 1'b0);
        sendWord(b, 0, 1'b0);
      end

    tag = "R4";
    for (int i = 0; i < 24; i++) sendWord((i * 5) % 16 - 8, 0, 1'b0);

    tag = "R5";
    for (int i = 0; i < 12; i++) sendWord(7 - i, i % 2, 1'b1);

    tag = "R7";
    for (int i = 0; i < TAPS + 1; i++) sendWord(-8, 0, 1'b0);
    for (int i = 0; i < TAPS + 1; i++) sendWord(7, 0, 1'b0);
    for (int i = 0; i < 2 * TAPS; i++) sendWord((i % 2) ? 7 : -8, 0, 1'b0);

    repeat (P + 4) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R5", expQ.size(), 0);
    check(pulses == accepted, "R4", pulses, accepted);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule